// File: doc/BRIEF.md
# Banked SPI Register Command Engine

This block is an SPI master that turns single host requests into complete serial transactions for a peripheral whose control registers are split into banks. A host request carries a 3-bit operation, an 8-bit register descriptor, a write byte and a stream length. The engine builds the command byte from the operation and the descriptor's register address and frames each transaction with chip select. It shifts bytes in SPI mode 0 at a rate set by a programmable half-period divider.

The descriptor packs three things. Bits 4:0 hold the register address. Bits 6:5 hold the bank the register lives in. Bit 7 marks a slow register class whose reads need one extra dummy byte. The engine keeps a copy of the bank currently selected in the peripheral. Before a banked register access to a different bank, it first sends two short frames: one clears the select field in the shared control register, and one sets the new bank. Registers at addresses 0x1B to 0x1F are visible in every bank and never cause a switch. Buffer operations keep chip select low for a host-given number of data bytes. Outgoing bytes are taken one at a time from the host, and incoming bytes are reported one at a time.

Top module: `spi_bank_engine`

## Requirements
- R1: The command byte is {op[2:0], desc[4:0]} for register operations: read 0, write 2, bit set 4, bit clear 5. For buffer read (op 1) the command byte is 0x3A, and for buffer write (op 3) it is 0x7A.
- R2: A register write, bit set or bit clear is one chip-select frame of two bytes: the command byte, then the write byte latched with the request.
- R3: A register read of a descriptor with bit 7 clear is a frame of two bytes, and rdata at ack is the byte received during the second transfer. With bit 7 set, the frame has three bytes and rdata is the byte received during the third transfer. Every byte sent after the command byte of a read is 0x00.
- R4: Consider a register operation whose address is below 0x1B and whose desc[6:5] differs from the cached bank. It is preceded by frame {0xBF, 0x03} and then frame {0x9F, {6'b0, desc[6:5]}}, and the cached bank becomes desc[6:5]. When the banks match, no extra frame is sent.
- R5: Register operations at addresses 0x1B to 0x1F send no bank frames and leave the cached bank unchanged.
- R6: A buffer operation with length N is a single frame of 1+N bytes. For a buffer write, each data byte is taken from wdata at its start, and a one-cycle wr_take pulse follows each take. For a buffer read, each received data byte appears on rdata with a one-cycle rd_valid pulse. N = 0 sends the command byte alone.
- R7: Op 7 (soft reset) sends the single byte 0xFF and sets the cached bank to 0. After reset, the cached bank is 0.
- R8: SPI mode 0: sck is low while cs_n is high, data goes out MSB first, and mosi only changes while sck is low.
- R9: ack is high for exactly one cycle, on the cycle cs_n returns high at the end of the request's last frame, with rdata valid.
- R10: Out of reset, cs_n is high, sck is low and ack is low.
- R11: Each sck high phase lasts half_div+1 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| half_div | input | DIV_W | sck half period minus one, in clocks |
| req | input | 1 | Request, sampled while idle; hold until ack |
| op | input | 3 | Operation code |
| desc | input | 8 | Register descriptor: address, bank, slow flag |
| wdata | input | 8 | Write byte; read live for each buffer write byte |
| len | input | LEN_W | Buffer stream length in bytes |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last received byte; stream byte on rd_valid |
| wr_take | output | 1 | Pulse after a buffer write byte was taken |
| rd_valid | output | 1 | Pulse with a buffer read byte on rdata |
| sck | output | 1 | SPI clock, mode 0 |
| mosi | output | 1 | SPI data out |
| miso | input | 1 | SPI data in |
| cs_n | output | 1 | Chip select, active low |

## Verification
The bench targets the bank cache. It moves between banks, then issues shared-address accesses and checks that a later access to the old bank sends no switch frames. It also checks that a soft reset brings the cache back to bank 0. A design that compared the wrong descriptor bits, or updated the cache on shared registers, would send extra select frames or leave out needed ones. Slow-register reads are checked against fast ones. A design that miscounted the dummy byte would return the first reply byte instead of the second. Zero-length and multi-byte streams are checked byte by byte against the per-byte take and valid pulses. Off-by-one length handling would show up as an extra or missing byte inside the frame.

// File: rtl/sbe_pkg.sv
package sbe_pkg;

   typedef enum logic [2:0] {
      OP_RD_REG   = 3'd0,
      OP_RD_BUF   = 3'd1,
      OP_WR_REG   = 3'd2,
      OP_WR_BUF   = 3'd3,
      OP_BIT_SET  = 3'd4,
      OP_BIT_CLR  = 3'd5,
      OP_CMD_ONLY = 3'd6,
      OP_RESET    = 3'd7
   } sbe_op_e;

   typedef enum logic [1:0] {
      FR_CLR,
      FR_SET,
      FR_MAIN
   } sbe_frame_e;

   localparam int ADDR_W   = 5;
   localparam int BANK_LSB = 5;
   localparam int BANK_W   = 2;
   localparam int SLOW_BIT = 7;

   localparam logic [ADDR_W-1:0] SHARED_FIRST = 5'h1B;
   localparam logic [ADDR_W-1:0] SEL_ADDR     = 5'h1F;
   localparam logic [ADDR_W-1:0] STREAM_ADDR  = 5'h1A;
   localparam logic [7:0]        SEL_FIELD    = 8'h03;
   localparam logic [7:0]        RESET_CMD    = 8'hFF;

   function automatic logic is_reg_op(input sbe_op_e o);
      return (o == OP_RD_REG) || (o == OP_WR_REG) ||
             (o == OP_BIT_SET) || (o == OP_BIT_CLR);
   endfunction

   function automatic logic [7:0] cmd_byte(input sbe_op_e o, input logic [ADDR_W-1:0] a);
      case (o)
         OP_RD_BUF, OP_WR_BUF: return {o, STREAM_ADDR};
         OP_RESET:             return RESET_CMD;
         default:              return {o, a};
      endcase
   endfunction

endpackage

// File: rtl/sbe_clkdiv.sv
module sbe_clkdiv #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] half_div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt_q;

   assign tick = en && (cnt_q == half_div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!en || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/sbe_shifter.sv
module sbe_shifter #(
   parameter bit LSB_FIRST = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic [7:0] tx_byte,
   input  logic       tick,
   input  logic       miso,
   output logic       sck,
   output logic       mosi,
   output logic       busy,
   output logic       done,
   output logic [7:0] rx_byte
);

   logic [2:0] bit_q;
   logic [7:0] tx_q;
   logic [7:0] rx_q;
   logic       sck_q;
   logic       busy_q;
   logic       done_q;
   logic [7:0] rx_next;
   logic [7:0] tx_shift;
   logic       out_bit;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign out_bit  = tx_q[0];
         assign rx_next  = {miso, rx_q[7:1]};
         assign tx_shift = {1'b0, tx_q[7:1]};
      end else begin : g_msb
         assign out_bit  = tx_q[7];
         assign rx_next  = {rx_q[6:0], miso};
         assign tx_shift = {tx_q[6:0], 1'b0};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_q  <= '0;
         tx_q   <= '0;
         rx_q   <= '0;
         sck_q  <= 1'b0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (start) begin
            busy_q <= 1'b1;
            tx_q   <= tx_byte;
            bit_q  <= '0;
            sck_q  <= 1'b0;
         end else if (busy_q && tick) begin
            sck_q <= ~sck_q;
            if (!sck_q) begin
               rx_q <= rx_next;
            end else begin
               tx_q  <= tx_shift;
               bit_q <= bit_q + 3'd1;
               if (bit_q == 3'd7) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end
            end
         end
      end
   end

   assign sck     = sck_q;
   assign mosi    = out_bit;
   assign busy    = busy_q;
   assign done    = done_q;
   assign rx_byte = rx_q;

endmodule

// File: rtl/spi_bank_engine.sv
module spi_bank_engine
   import sbe_pkg::*;
#(
   parameter int DIV_W     = 8,
   parameter int LEN_W     = 6,
   parameter bit LSB_FIRST = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] half_div,
   input  logic             req,
   input  logic [2:0]       op,
   input  logic [7:0]       desc,
   input  logic [7:0]       wdata,
   input  logic [LEN_W-1:0] len,
   output logic             ack,
   output logic [7:0]       rdata,
   output logic             wr_take,
   output logic             rd_valid,
   output logic             sck,
   output logic             mosi,
   input  logic             miso,
   output logic             cs_n
);

   localparam int IDX_W = LEN_W;

   generate
      if (LEN_W < 2) begin : g_bad_len
         $error("LEN_W must be at least 2");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("DIV_W must be at least 1");
      end
   endgenerate

   typedef enum logic [1:0] {S_IDLE, S_GAP, S_LOAD, S_BYTE} st_e;

   st_e                st_q;
   sbe_frame_e         frame_q;
   sbe_op_e            op_q;
   sbe_op_e            op_in;
   logic [7:0]         desc_q;
   logic [7:0]         wbyte_q;
   logic [LEN_W-1:0]   len_q;
   logic [IDX_W-1:0]   idx_q;
   logic [IDX_W-1:0]   last_q;
   logic [BANK_W-1:0]  bank_q;
   logic               cs_n_q;
   logic               ack_q;
   logic               take_q;
   logic               rdv_q;
   logic [7:0]         rdata_q;

   logic               tick;
   logic               sh_busy;
   logic               sh_done;
   logic [7:0]         sh_rx;
   logic [7:0]         tx_sel;
   logic               need_switch;
   logic [BANK_W-1:0]  bank_in;

   function automatic logic [IDX_W-1:0] last_index(input sbe_op_e o, input logic slow,
                                                   input logic [LEN_W-1:0] n);
      case (o)
         OP_RD_REG:                        return slow ? IDX_W'(2) : IDX_W'(1);
         OP_WR_REG, OP_BIT_SET, OP_BIT_CLR: return IDX_W'(1);
         OP_RD_BUF, OP_WR_BUF:             return IDX_W'(n);
         default:                          return '0;
      endcase
   endfunction

   assign op_in       = sbe_op_e'(op);
   assign bank_in     = desc[BANK_LSB +: BANK_W];
   assign need_switch = is_reg_op(op_in) && (desc[ADDR_W-1:0] < SHARED_FIRST) &&
                        (bank_in != bank_q);

   // byte presented to the shifter for the current frame position
   always_comb begin
      tx_sel = 8'h00;
      case (frame_q)
         FR_CLR:  tx_sel = (idx_q == '0) ? cmd_byte(OP_BIT_CLR, SEL_ADDR) : SEL_FIELD;
         FR_SET:  tx_sel = (idx_q == '0) ? cmd_byte(OP_BIT_SET, SEL_ADDR)
                                         : 8'(desc_q[BANK_LSB +: BANK_W]);
         default: begin
            if (idx_q == '0) begin
               tx_sel = cmd_byte(op_q, desc_q[ADDR_W-1:0]);
            end else if (op_q == OP_WR_BUF) begin
               tx_sel = wdata;
            end else if ((op_q == OP_WR_REG) || (op_q == OP_BIT_SET) || (op_q == OP_BIT_CLR)) begin
               tx_sel = wbyte_q;
            end else begin
               tx_sel = 8'h00;
            end
         end
      endcase
   end

   sbe_clkdiv #(.DIV_W(DIV_W)) i_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (sh_busy || (st_q == S_GAP)),
      .half_div (half_div),
      .tick     (tick)
   );

   sbe_shifter #(.LSB_FIRST(LSB_FIRST)) i_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (st_q == S_LOAD),
      .tx_byte (tx_sel),
      .tick    (tick),
      .miso    (miso),
      .sck     (sck),
      .mosi    (mosi),
      .busy    (sh_busy),
      .done    (sh_done),
      .rx_byte (sh_rx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= S_IDLE;
         frame_q <= FR_MAIN;
         op_q    <= OP_RD_REG;
         desc_q  <= '0;
         wbyte_q <= '0;
         len_q   <= '0;
         idx_q   <= '0;
         last_q  <= '0;
         bank_q  <= '0;
         cs_n_q  <= 1'b1;
         ack_q   <= 1'b0;
         take_q  <= 1'b0;
         rdv_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         ack_q  <= 1'b0;
         take_q <= 1'b0;
         rdv_q  <= 1'b0;
         case (st_q)
            S_IDLE: begin
               if (req) begin
                  op_q    <= op_in;
                  desc_q  <= desc;
                  wbyte_q <= wdata;
                  len_q   <= len;
                  idx_q   <= '0;
                  frame_q <= need_switch ? FR_CLR : FR_MAIN;
                  last_q  <= need_switch ? IDX_W'(1) : last_index(op_in, desc[SLOW_BIT], len);
                  cs_n_q  <= 1'b0;
                  st_q    <= S_LOAD;
               end
            end
            S_GAP: begin
               if (tick) begin
                  cs_n_q <= 1'b0;
                  st_q   <= S_LOAD;
               end
            end
            S_LOAD: begin
               take_q <= (frame_q == FR_MAIN) && (op_q == OP_WR_BUF) && (idx_q != '0);
               st_q   <= S_BYTE;
            end
            default: begin
               if (sh_done) begin
                  if ((frame_q == FR_MAIN) && (op_q == OP_RD_BUF) && (idx_q != '0)) begin
                     rdv_q   <= 1'b1;
                     rdata_q <= sh_rx;
                  end
                  if (idx_q != last_q) begin
                     idx_q <= idx_q + 1'b1;
                     st_q  <= S_LOAD;
                  end else begin
                     cs_n_q <= 1'b1;
                     idx_q  <= '0;
                     case (frame_q)
                        FR_CLR: begin
                           frame_q <= FR_SET;
                           last_q  <= IDX_W'(1);
                           st_q    <= S_GAP;
                        end
                        FR_SET: begin
                           bank_q  <= desc_q[BANK_LSB +: BANK_W];
                           frame_q <= FR_MAIN;
                           last_q  <= last_index(op_q, desc_q[SLOW_BIT], len_q);
                           st_q    <= S_GAP;
                        end
                        default: begin
                           ack_q   <= 1'b1;
                           rdata_q <= sh_rx;
                           if (op_q == OP_RESET) begin
                              bank_q <= '0;
                           end
                           st_q <= S_IDLE;
                        end
                     endcase
                  end
               end
            end
         endcase
      end
   end

   assign cs_n     = cs_n_q;
   assign ack      = ack_q;
   assign rdata    = rdata_q;
   assign wr_take  = take_q;
   assign rd_valid = rdv_q;

endmodule

// File: rtl/sbe_checker.sv
module sbe_checker (
   input logic clk,
   input logic rst_n,
   input logic cs_n,
   input logic sck,
   input logic mosi,
   input logic ack,
   input logic wr_take
);

   AST_ACK_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> $rose(cs_n)); // R9

   AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack); // R9

   AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sck); // R8

   AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck)) |-> $stable(mosi)); // R8

   AST_TAKE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      wr_take |-> !cs_n); // R6

endmodule

bind spi_bank_engine sbe_checker i_sbe_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .cs_n    (cs_n),
   .sck     (sck),
   .mosi    (mosi),
   .ack     (ack),
   .wr_take (wr_take)
);

// File: tb/test_spi_bank_engine.sv
module test_spi_bank_engine;

   localparam int CLK_PERIOD = 10;
   localparam int DIV_W = 8;
   localparam int LEN_W = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [DIV_W-1:0] half_div = 8'd1;
   logic             req = 1'b0;
   logic [2:0]       op = '0;
   logic [7:0]       desc = '0;
   logic [7:0]       wdata = '0;
   logic [LEN_W-1:0] len = '0;
   logic             ack, wr_take, rd_valid, sck, mosi, cs_n;
   logic             miso = 1'b0;
   logic [7:0]       rdata;

   int n_chk = 0;
   int n_bad = 0;
   bit done_flag = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_bank_engine #(.DIV_W(DIV_W), .LEN_W(LEN_W)) i_spi_bank_engine (
      .clk(clk), .rst_n(rst_n), .half_div(half_div), .req(req), .op(op),
      .desc(desc), .wdata(wdata), .len(len), .ack(ack), .rdata(rdata),
      .wr_take(wr_take), .rd_valid(rd_valid), .sck(sck), .mosi(mosi),
      .miso(miso), .cs_n(cs_n)
   );

   function automatic logic [7:0] rep(input int k);
      return 8'h3C + 8'(k * 37);
   endfunction

   // ---------------- SPI peripheral model ----------------
   logic [7:0] fr [0:15][0:31];
   int         fr_len [0:15];
   int         nfr = 0;
   int         sbits = 0;
   logic [7:0] ssh = '0;

   always @(negedge cs_n) begin
      sbits = 0;
      miso  = rep(0)[7];
   end
   always @(posedge sck) if (!cs_n) begin
      ssh   = {ssh[6:0], mosi};
      sbits = sbits + 1;
      if ((sbits % 8) == 0 && nfr < 16 && (sbits / 8) <= 32) fr[nfr][sbits/8 - 1] = ssh;
   end
   always @(negedge sck) if (!cs_n) begin
      miso = rep(sbits / 8)[7 - (sbits % 8)];
   end
   always @(posedge cs_n) begin
      if (nfr < 16) fr_len[nfr] = sbits / 8;
      nfr = nfr + 1;
   end

   // ---------------- host side monitors ----------------
   logic [7:0] bufd [0:7];
   logic [7:0] rdb [0:7];
   int wcnt = 0;
   int rcnt = 0;
   int ack_cnt = 0;
   int hcnt = 0;
   int last_hw = 0;
   int viol = 0;
   logic prev_sck = 1'b0;
   logic prev_mosi = 1'b0;

   always @(negedge clk) begin
      if (ack) ack_cnt = ack_cnt + 1;
      if (wr_take) begin
         wcnt  = wcnt + 1;
         wdata = bufd[wcnt % 8];
      end
      if (rd_valid) begin
         rdb[rcnt % 8] = rdata;
         rcnt = rcnt + 1;
      end
      if (sck) hcnt = hcnt + 1;
      else if (hcnt != 0) begin
         last_hw = hcnt;
         hcnt = 0;
      end
      if (sck && prev_sck && (mosi !== prev_mosi)) viol = viol + 1;
      prev_sck  = sck;
      prev_mosi = mosi;
   end

   // ---------------- check helpers ----------------
   task automatic chk(input string rq, input int act, input int exp);
      n_chk = n_chk + 1;
      if (act !== exp) begin
         n_bad = n_bad + 1;
         $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
      end
   endtask

   task automatic chk_frame(input string rq, input int f, input int n, input logic [63:0] e);
      chk({rq, " frame length"}, fr_len[f], n);
      for (int b = 0; b < n; b++) chk({rq, " frame byte"}, fr[f][b], e[63 - 8*b -: 8]);
   endtask

   task automatic do_cmd(input logic [2:0] o, input logic [7:0] d, input logic [7:0] w,
                         input int n, output logic [7:0] rd);
      int a0;
      int t;
      a0 = ack_cnt;
      nfr = 0;
      wcnt = 0;
      rcnt = 0;
      @(negedge clk);
      req = 1'b1; op = o; desc = d; wdata = w; len = LEN_W'(n);
      t = 0;
      do begin
         @(negedge clk);
         t++;
      end while (!ack && t < 20000);
      chk("R9 ack arrives", int'(ack), 1);
      rd = rdata;
      req = 1'b0;
      repeat (3) @(negedge clk);
      chk("R9 ack lasts one cycle", ack_cnt - a0, 1);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      chk("R10 cs_n after reset", int'(cs_n), 1);
      chk("R10 sck after reset", int'(sck), 0);
      chk("R10 ack after reset", int'(ack), 0);
   endtask

   task automatic t_write_same_bank();
      logic [7:0] r;
      do_cmd(3'd2, 8'h05, 8'h5A, 0, r);
      chk("R7 R4 no switch from reset bank 0", nfr, 1);
      chk_frame("R1 R2 write", 0, 2, {8'h45, 8'h5A, 48'h0});
      chk("R11 sck high width", last_hw, 2);
   endtask

   task automatic t_write_switch();
      logic [7:0] r;
      do_cmd(3'd2, 8'h4A, 8'hC3, 0, r);
      chk("R4 frame count", nfr, 3);
      chk_frame("R4 clear select", 0, 2, {8'hBF, 8'h03, 48'h0});
      chk_frame("R4 set select", 1, 2, {8'h9F, 8'h02, 48'h0});
      chk_frame("R4 R2 main write", 2, 2, {8'h4A, 8'hC3, 48'h0});
   endtask

   task automatic t_reads();
      logic [7:0] r;
      do_cmd(3'd0, 8'h47, 8'h00, 0, r);
      chk("R4 same bank read frames", nfr, 1);
      chk_frame("R3 fast read", 0, 2, {8'h07, 8'h00, 48'h0});
      chk("R3 fast read data", r, rep(1));
      do_cmd(3'd0, 8'hC3, 8'h00, 0, r);
      chk_frame("R3 slow read", 0, 3, {8'h03, 8'h00, 8'h00, 40'h0});
      chk("R3 slow read data", r, rep(2));
   endtask

   task automatic t_shared();
      logic [7:0] r;
      do_cmd(3'd4, 8'h7F, 8'h10, 0, r);
      chk("R5 shared set no switch", nfr, 1);
      chk_frame("R5 shared set", 0, 2, {8'h9F, 8'h10, 48'h0});
      do_cmd(3'd2, 8'h3B, 8'h66, 0, r);
      chk("R5 shared write no switch", nfr, 1);
      chk_frame("R5 shared write", 0, 2, {8'h5B, 8'h66, 48'h0});
      do_cmd(3'd0, 8'h48, 8'h00, 0, r);
      chk("R5 cache kept at bank 2", nfr, 1);
      chk_frame("R5 read old bank", 0, 2, {8'h08, 8'h00, 48'h0});
   endtask

   task automatic t_clear_switch();
      logic [7:0] r;
      do_cmd(3'd5, 8'h21, 8'h0F, 0, r);
      chk("R4 clear op frames", nfr, 3);
      chk_frame("R4 clear op select clear", 0, 2, {8'hBF, 8'h03, 48'h0});
      chk_frame("R4 clear op select set", 1, 2, {8'h9F, 8'h01, 48'h0});
      chk_frame("R1 bit clear command", 2, 2, {8'hA1, 8'h0F, 48'h0});
   endtask

   task automatic t_stream_write();
      logic [7:0] r;
      bufd[0] = 8'h11; bufd[1] = 8'h22; bufd[2] = 8'h33; bufd[3] = 8'h44;
      bufd[4] = 8'hEE; bufd[5] = 8'hEE; bufd[6] = 8'hEE; bufd[7] = 8'hEE;
      do_cmd(3'd3, 8'h05, bufd[0], 4, r);
      chk("R6 write stream one frame", nfr, 1);
      chk_frame("R6 R1 write stream", 0, 5, {8'h7A, 8'h11, 8'h22, 8'h33, 8'h44, 24'h0});
      chk("R6 write take pulses", wcnt, 4);
   endtask

   task automatic t_stream_read();
      logic [7:0] r;
      do_cmd(3'd1, 8'h00, 8'h00, 3, r);
      chk_frame("R6 R1 read stream", 0, 4, {8'h3A, 8'h00, 8'h00, 8'h00, 32'h0});
      chk("R6 read valid pulses", rcnt, 3);
      for (int k = 0; k < 3; k++) chk("R6 read stream byte", rdb[k], rep(k + 1));
      chk("R6 read stream last at ack", r, rep(3));
      do_cmd(3'd1, 8'h00, 8'h00, 0, r);
      chk_frame("R6 zero length stream", 0, 1, {8'h3A, 56'h0});
      chk("R6 zero length no valid", rcnt, 0);
   endtask

   task automatic t_soft_reset();
      logic [7:0] r;
      do_cmd(3'd7, 8'h00, 8'h00, 0, r);
      chk_frame("R7 soft reset", 0, 1, {8'hFF, 56'h0});
      do_cmd(3'd2, 8'h02, 8'h77, 0, r);
      chk("R7 cache back to bank 0", nfr, 1);
      chk_frame("R7 write after soft reset", 0, 2, {8'h42, 8'h77, 48'h0});
   endtask

   task automatic t_slow_clock();
      logic [7:0] r;
      half_div = 8'd3;
      do_cmd(3'd2, 8'h61, 8'h99, 0, r);
      chk("R11 sck high width slow", last_hw, 4);
      chk("R4 switch to bank 3 frames", nfr, 3);
      chk_frame("R4 set bank 3", 1, 2, {8'h9F, 8'h03, 48'h0});
      half_div = 8'd1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_write_same_bank();
      t_write_switch();
      t_reads();
      t_shared();
      t_clear_switch();
      t_stream_write();
      t_stream_read();
      t_soft_reset();
      t_slow_clock();
      chk("R8 mosi stable while sck high", viol, 0);
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done_flag) begin
         n_chk = n_chk + 1;
         n_bad = n_bad + 1;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule